// File: doc/BRIEF.md
# Four-stage nonlinear shift register, Fibonacci and Galois forms

This block is a four-stage nonlinear feedback shift register that produces one pseudo-random bit per enabled clock. A parameter picks one of five feedback function sets. Two are Fibonacci forms, where all nonlinear feedback enters the top stage. Three are Galois forms, where part of the feedback is moved into stage 2. This shortens the worst path into the top stage. Stage 0 drives the serial output.

A 4-bit seed is loaded by pulsing `load`. In a Galois form, stage 2 receives extra terms, so stage 3 no longer holds a plain delayed copy of the output stream. For that reason, the load path translates the seed before writing stage 3. With this translation, every configuration emits the seed bits 0, 1, 2, 3 as its first four outputs. Each Galois form that is equivalent to a Fibonacci form then produces exactly the same sequence as that form. `en` gates the shifting, and `load` overrides it.

The first Galois form moves the term x1·x2 to stage 2 as x0·x1 and keeps x2·x3 in the top stage. Its output obeys a recurrence with an extra cubic term. It is therefore not equivalent to the first Fibonacci form, and it is checked against its own recurrence.

Top module: `nlfsr4`

## Requirements
- R1: While `rst_n` is low the register takes the parameter value `RST_VAL` (default 4'b1001), so `dout` reads `RST_VAL[0]` (1) after reset.
- R2: A cycle with `load` high writes the register whatever `en` is. After that edge `dout` equals `seed[0]`, and with `en` high on the following clocks it shows `seed[1]`, `seed[2]`, `seed[3]` in that order, in every configuration.
- R3: Each clock with `en` high and `load` low moves the value of stage 1 onto `dout`, and stages 0 and 1 take the old values of stages 1 and 2.
- R4: A clock with `en` and `load` both low leaves the register and `dout` unchanged, and the sequence resumes where it stopped.
- R5: With `CFG = CFG_FIB_A` the output bits obey o[t+4] = o[t] ^ o[t+2]·o[t+3] ^ o[t+1]·o[t+2].
- R6: With `CFG = CFG_FIB_B` the output bits obey o[t+4] = o[t] ^ o[t+1]·o[t+2] ^ o[t+1]·o[t+3].
- R7: With `CFG = CFG_GAL_B1` (top x0 ^ x1·x2, stage 2 x3 ^ x0·x2), the output from any seed equals the `CFG_FIB_B` output from the same seed.
- R8: With `CFG = CFG_GAL_B2` (top x0, stage 2 x3 ^ x0·x1 ^ x0·x2), the output from any seed equals the `CFG_FIB_B` output from the same seed.
- R9: With `CFG = CFG_GAL_A` (top x0 ^ x2·x3, stage 2 x3 ^ x0·x1) the output obeys the R5 recurrence plus the term o[t]·o[t+1]·o[t+2]. From seed 4'b0111 its fifth output bit is 1, where `CFG_FIB_A` gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset to `RST_VAL` |
| en | input | 1 | Shift enable |
| load | input | 1 | Seed write strobe, overrides `en` |
| seed | input | 4 | Seed value, bit 0 is the first output bit |
| dout | output | 1 | Serial output, stage 0 |

## Verification
A corrupted stage shows at `dout` within at most three enabled clocks, because stage 3 reaches stage 0 after three shifts. Corruption also feeds back into every later bit through the nonlinear terms. A wrong seed translation leaves the first three bits correct, then spoils the fourth bit and the rest of the sequence. Comparing each Galois form against the Fibonacci form over long runs from several seeds, with enable gaps, therefore exposes both feedback and load faults within a few cycles of their first effect.

// File: rtl/nlfsr4_pkg.sv
package nlfsr4_pkg;

   localparam int unsigned NLFSR_LEN = 4;

   typedef enum logic [2:0] {
      CFG_FIB_A  = 3'd0,
      CFG_GAL_A  = 3'd1,
      CFG_FIB_B  = 3'd2,
      CFG_GAL_B1 = 3'd3,
      CFG_GAL_B2 = 3'd4
   } nlfsr_cfg_e;

endpackage

// File: rtl/nlfsr4_feedback.sv
module nlfsr4_feedback
   import nlfsr4_pkg::*;
#(
   parameter nlfsr_cfg_e  CFG = CFG_FIB_B,
   parameter int unsigned LEN = NLFSR_LEN
) (
   input  logic [LEN-1:0] cur,
   output logic [LEN-1:0] nxt
);

   localparam int unsigned TOP = LEN - 1;
   localparam int unsigned MID = LEN - 2;

   if (LEN != 4) begin : g_len_chk
      $error("nlfsr4_feedback: function sets are defined for exactly 4 stages");
   end

   for (genvar i = 0; i < MID; i++) begin : g_shift
      assign nxt[i] = cur[i+1];
   end

   case (CFG)
      CFG_FIB_A: begin : g_fib_a
         assign nxt[MID] = cur[TOP];
         assign nxt[TOP] = cur[0] ^ (cur[2] & cur[3]) ^ (cur[1] & cur[2]);
      end
      CFG_GAL_A: begin : g_gal_a
         assign nxt[MID] = cur[TOP] ^ (cur[0] & cur[1]);
         assign nxt[TOP] = cur[0] ^ (cur[2] & cur[3]);
      end
      CFG_FIB_B: begin : g_fib_b
         assign nxt[MID] = cur[TOP];
         assign nxt[TOP] = cur[0] ^ (cur[1] & cur[2]) ^ (cur[1] & cur[3]);
      end
      CFG_GAL_B1: begin : g_gal_b1
         assign nxt[MID] = cur[TOP] ^ (cur[0] & cur[2]);
         assign nxt[TOP] = cur[0] ^ (cur[1] & cur[2]);
      end
      CFG_GAL_B2: begin : g_gal_b2
         assign nxt[MID] = cur[TOP] ^ (cur[0] & cur[1]) ^ (cur[0] & cur[2]);
         assign nxt[TOP] = cur[0];
      end
      default: begin : g_bad_cfg
         $error("nlfsr4_feedback: unknown configuration");
      end
   endcase

endmodule

// File: rtl/nlfsr4_seed_map.sv
module nlfsr4_seed_map
   import nlfsr4_pkg::*;
#(
   parameter nlfsr_cfg_e  CFG = CFG_FIB_B,
   parameter int unsigned LEN = NLFSR_LEN
) (
   input  logic [LEN-1:0] seed,
   output logic [LEN-1:0] init
);

   localparam int unsigned TOP = LEN - 1;

   logic fix;

   // Stage 3 is pre-corrected by the terms that the Galois form injects
   // into stage 2, so the fourth output bit equals seed[3].
   case (CFG)
      CFG_GAL_A: begin : g_fix_a
         assign fix = seed[0] & seed[1];
      end
      CFG_GAL_B1: begin : g_fix_b1
         assign fix = seed[0] & seed[2];
      end
      CFG_GAL_B2: begin : g_fix_b2
         assign fix = (seed[0] & seed[1]) ^ (seed[0] & seed[2]);
      end
      default: begin : g_fix_none
         assign fix = 1'b0;
      end
   endcase

   assign init[TOP-1:0] = seed[TOP-1:0];
   assign init[TOP]     = seed[TOP] ^ fix;

endmodule

// File: rtl/nlfsr4.sv
module nlfsr4
   import nlfsr4_pkg::*;
#(
   parameter nlfsr_cfg_e  CFG     = CFG_FIB_B,
   parameter logic [3:0]  RST_VAL = 4'b1001
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       load,
   input  logic [3:0] seed,
   output logic       dout
);

   localparam int unsigned LEN     = NLFSR_LEN;
   localparam bit          IS_FIB  = (CFG == CFG_FIB_A) || (CFG == CFG_FIB_B);

   if ($bits(seed) != LEN) begin : g_width_chk
      $error("nlfsr4: seed width must match register length");
   end

   logic [LEN-1:0] state_q;
   logic [LEN-1:0] state_nxt;
   logic [LEN-1:0] load_val;

   nlfsr4_feedback #(.CFG(CFG), .LEN(LEN)) u_fb (
      .cur (state_q),
      .nxt (state_nxt)
   );

   nlfsr4_seed_map #(.CFG(CFG), .LEN(LEN)) u_map (
      .seed (seed),
      .init (load_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RST_VAL;
      end else if (load) begin
         state_q <= load_val;
      end else if (en) begin
         state_q <= state_nxt;
      end
   end

   assign dout = state_q[0];

   // R1
   a_r1_reset_value: assert property (@(posedge clk)
      !rst_n |=> state_q == RST_VAL);

   // R2
   a_r2_load_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> dout == $past(seed[0]));

   a_r2_load_low_stages: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> state_q[2:1] == $past(seed[2:1]));

   // R3
   a_r3_shift_out: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |=> dout == $past(state_q[1]));

   a_r3_stage1_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |=> state_q[1] == $past(state_q[2]));

   // R4
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(state_q));

   // R5 / R6: Fibonacci forms keep stage 2 a pure delay of stage 3
   if (IS_FIB) begin : g_fib_chk
      a_r6_fib_stage2_shift: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !load) |=> state_q[2] == $past(state_q[3]));
   end

endmodule

// File: tb/nlfsr4_tb.sv
module nlfsr4_tb;
   import nlfsr4_pkg::*;

   localparam int CMP_OFFSET = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       load = 1'b0;
   logic [3:0] seed = 4'b0000;
   logic       o_fb, o_b1, o_b2, o_fa, o_ga;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nlfsr4 #(.CFG(CFG_FIB_B))  u_dut    (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .dout(o_fb));
   nlfsr4 #(.CFG(CFG_GAL_B1)) u_gal_b1 (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .dout(o_b1));
   nlfsr4 #(.CFG(CFG_GAL_B2)) u_gal_b2 (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .dout(o_b2));
   nlfsr4 #(.CFG(CFG_FIB_A))  u_fib_a  (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .dout(o_fa));
   nlfsr4 #(.CFG(CFG_GAL_A))  u_gal_a  (.clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .dout(o_ga));

   // Output-bit recurrences; w[0] is the current output bit.
   function automatic logic rec_a(input logic [3:0] w);
      return w[0] ^ (w[2] & w[3]) ^ (w[1] & w[2]);
   endfunction
   function automatic logic rec_ga(input logic [3:0] w);
      return rec_a(w) ^ (w[0] & w[1] & w[2]);
   endfunction
   function automatic logic rec_b(input logic [3:0] w);
      return w[0] ^ (w[1] & w[2]) ^ (w[1] & w[3]);
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic do_load(input logic [3:0] s, input logic with_en);
      load = 1'b1; en = with_en; seed = s;
      @(negedge clk);
      load = 1'b0; en = 1'b0;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "fib_b reset", o_fb, 1'b1);
      chk("R1", "gal_b1 reset", o_b1, 1'b1);
      chk("R1", "gal_a reset", o_ga, 1'b1);
   endtask

   task automatic test_load_priority();
      en = 1'b1;
      repeat (3) @(negedge clk);
      do_load(4'b0110, 1'b1);
      chk("R2", "load with en fib_b", o_fb, 1'b0);
      chk("R2", "load with en gal_b2", o_b2, 1'b0);
      load = 1'b1; en = 1'b1; seed = 4'b1011;
      @(negedge clk);
      @(negedge clk);
      load = 1'b0; en = 1'b0;
      chk("R2", "held load fib_a", o_fa, 1'b1);
      chk("R2", "held load gal_a", o_ga, 1'b1);
   endtask

   task automatic test_first_bits(input logic [3:0] s);
      do_load(s, 1'b0);
      for (int k = 0; k < 4; k++) begin
         chk("R2", "seed bit fib_b", o_fb, s[k]);
         chk("R2", "seed bit gal_b1", o_b1, s[k]);
         chk("R2", "seed bit gal_b2", o_b2, s[k]);
         chk("R2", "seed bit fib_a", o_fa, s[k]);
         chk("R2", "seed bit gal_a", o_ga, s[k]);
         en = 1'b1;
         @(negedge clk);
         en = 1'b0;
      end
   endtask

   task automatic test_shift_step();
      do_load(4'b1010, 1'b0);
      en = 1'b1;
      @(negedge clk);
      chk("R3", "step 1", o_fb, 1'b1);
      @(negedge clk);
      chk("R3", "step 2", o_fb, 1'b0);
      @(negedge clk);
      chk("R3", "step 3", o_fb, 1'b1);
      en = 1'b0;
   endtask

   task automatic test_hold();
      logic held;
      do_load(4'b1100, 1'b0);
      en = 1'b1;
      repeat (2) @(negedge clk);
      en = 1'b0;
      held = o_fb;
      chk("R4", "value before gap", held, 1'b1);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R4", "hold while en low", o_fb, held);
      end
      en = 1'b1;
      @(negedge clk);
      chk("R4", "resume after gap", o_fb, 1'b1);
      en = 1'b0;
   endtask

   task automatic run_seq(input logic [3:0] s, input int steps, input bit gaps);
      logic [3:0] wa, wg, wb;
      int idx;
      logic prev_en;
      logic prev_fb;
      wa = s; wg = s; wb = s; idx = 0; prev_en = 1'b1; prev_fb = 1'b0;
      do_load(s, 1'b0);
      for (int k = 0; k < steps; k++) begin
         chk("R5", "fib_a sequence", o_fa, wa[0]);
         chk("R9", "gal_a sequence", o_ga, wg[0]);
         chk("R6", "fib_b sequence", o_fb, wb[0]);
         chk("R7", "gal_b1 sequence", o_b1, wb[0]);
         chk("R8", "gal_b2 sequence", o_b2, wb[0]);
         if (idx >= CMP_OFFSET) begin
            chk("R7", "gal_b1 vs fib_b", o_b1, o_fb);
            chk("R8", "gal_b2 vs fib_b", o_b2, o_fb);
         end
         if (!prev_en) chk("R4", "no step while en low", o_fb, prev_fb);
         prev_fb = o_fb;
         en = gaps ? ((k % 4) != 2) : 1'b1;
         prev_en = en;
         @(negedge clk);
         if (prev_en) begin
            wa = {rec_a(wa), wa[3:1]};
            wg = {rec_ga(wg), wg[3:1]};
            wb = {rec_b(wb), wb[3:1]};
            idx++;
         end
      end
      en = 1'b0;
   endtask

   task automatic test_gal_a_diverges();
      do_load(4'b0111, 1'b0);
      en = 1'b1;
      repeat (4) @(negedge clk);
      en = 1'b0;
      chk("R9", "gal_a fifth bit from 0111", o_ga, 1'b1);
      chk("R5", "fib_a fifth bit from 0111", o_fa, 1'b0);
   endtask

   initial begin
      test_reset();
      test_load_priority();
      test_first_bits(4'b1011);
      test_first_bits(4'b0101);
      test_shift_step();
      test_hold();
      run_seq(4'b1011, 40, 1'b0);
      run_seq(4'b0111, 40, 1'b1);
      run_seq(4'b0001, 30, 1'b0);
      run_seq(4'b1111, 30, 1'b1);
      run_seq(4'b0110, 30, 1'b0);
      test_gal_a_diverges();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule